// File: doc/BRIEF.md
# Stream-to-CPU Receive Buffer

This block takes in an AXI4-Stream of 8, 16 or 32-bit beats and collects them into 32-bit words. Each word goes into an internal FIFO together with a frame-end flag and a per-byte valid mask. A processor empties the FIFO through a small register window. Each read of the data register removes one word, and the status register then describes the word just removed. The same FIFO can also be drained by a DMA engine through a second AXI4-Stream port. The block can be enabled or stopped, it has a soft reset that discards buffered data, and an interrupt line stays high while the FIFO holds at least a programmed number of words.

Register map (word index on `cpuAddr`): 0 data (read pops), 1 status, 2 control, 3 threshold, 4 level. Any other index reads as zero.

Top module: `strm_rx_buffer`

## Requirements
- R1: Beats are packed little-endian. With BEATS = 32/TDATA_W, the first beat of a word fills bits [TDATA_W-1:0], the next beat fills the lane above it, and the word enters the FIFO when its last lane is written.
- R2: An accepted beat with `sTlast` high sends the word to the FIFO at once, even if it is only partly filled. Lanes that were not received read as zero. The mask has bit i set only for byte i that was received. The word carries a frame-end flag of 1.
- R3: Reading index 0 returns the data of the oldest FIFO word and removes it at that clock edge. When the FIFO is empty the read returns 0 and removes nothing.
- R4: Status (index 1) bits are: bit0 = empty, bit1 = full, bit2 = frame-end flag of the most recently removed word, bits[7:4] = byte mask of that word. A word without a frame end always reports mask 4'hF.
- R5: Control (index 2) bit0 is the enable. While the enable is 0, `sTready` is low and no beat is accepted.
- R6: `sTready` is low whenever the FIFO holds DEPTH words (default 16).
- R7: Writing 1 to control bit1 produces a single-cycle internal clear in the next cycle. The clear empties the FIFO, drops a partly packed word and zeroes status bits 2 and 4 to 7. Enable, DMA select and threshold keep their values, and bit1 reads back as 0.
- R8: Index 4 reads the FIFO level in words. The level never exceeds DEPTH and changes by at most one per cycle except on a clear.
- R9: `irq` is high exactly when the level is greater than or equal to the threshold register (index 3). The threshold resets to 1.
- R10: With control bit2 set, `mTvalid` equals "FIFO not empty". `mTdata`, `mTkeep` and `mTlast` show the oldest word, a word is removed on `mTvalid && mTready`, and reads of index 0 remove nothing. With bit2 clear, `mTvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sTdata | input | TDATA_W | Inbound stream data |
| sTvalid | input | 1 | Inbound beat valid |
| sTready | output | 1 | Inbound beat accept |
| sTlast | input | 1 | Inbound frame end |
| mTdata | output | 32 | DMA stream data |
| mTkeep | output | 4 | DMA stream byte mask |
| mTlast | output | 1 | DMA stream frame end |
| mTvalid | output | 1 | DMA stream valid |
| mTready | input | 1 | DMA stream accept |
| cpuAddr | input | 3 | Register word index |
| cpuWrEn | input | 1 | Register write strobe |
| cpuWrData | input | 32 | Register write data |
| cpuRdEn | input | 1 | Register read strobe (pops on index 0) |
| cpuRdData | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level threshold interrupt |

## Verification
The checks distinguish three input patterns:

- Full four-beat words confirm lane ordering.
- Frames ending after one, two or three beats confirm that partial words are flushed and zero-filled and that their masks are correct.
- Random frame lengths from one to nine beats mix full and partial words across frame boundaries, which exposes any packer state that leaks from one frame into the next.

Directed cases cover the remaining behaviour. Filling the FIFO to its depth separates stall-when-full from stall-when-disabled. A soft reset issued between beats shows whether partly packed data is dropped. Switching the DMA port on shows whether the processor read path still removes words.

// File: rtl/strm_rx_pkg.sv
package strm_rx_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd1;
  localparam logic [2:0] REG_CTRL   = 3'd2;
  localparam logic [2:0] REG_THRESH = 3'd3;
  localparam logic [2:0] REG_LEVEL  = 3'd4;

  typedef struct packed {
    logic              last;
    logic [LANES-1:0]  mask;
    logic [WORD_W-1:0] data;
  } fifoWord_t;

  typedef struct packed {
    logic pop;
    logic clear;
    logic acceptEn;
    logic dmaMode;
  } ctlStrobes_t;
endpackage

// File: rtl/strm_rx_datapath.sv
module strm_rx_datapath
  import strm_rx_pkg::*;
#(
  parameter int TDATA_W = 8,
  parameter int DEPTH   = 16,
  parameter int LVL_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [TDATA_W-1:0] sTdata,
  input  logic               sTvalid,
  input  logic               sTlast,
  output logic               sTready,
  output fifoWord_t          head,
  output logic               empty,
  output logic               full,
  output logic [LVL_W-1:0]   level,
  output logic               mTvalid
);
  localparam int BEATS = WORD_W / TDATA_W;
  localparam int BYTES = TDATA_W / 8;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // packer state
  logic [WORD_W-1:0] accData, newData;
  logic [LANES-1:0]  accMask, newMask;
  logic [IDX_W-1:0]  lane;
  logic              beatFire, wordDone, pushWord;

  assign beatFire = sTvalid & sTready;

  always_comb begin
    newData = accData;
    newMask = accMask;
    for (int i = 0; i < BEATS; i++) begin
      if (lane == IDX_W'(i)) begin
        newData[i*TDATA_W +: TDATA_W] = sTdata;
        newMask[i*BYTES +: BYTES]     = '1;
      end
    end
  end

  generate
    if (BEATS == 1) begin : g_wide
      assign wordDone = 1'b1;
    end else begin : g_narrow
      assign wordDone = (lane == IDX_W'(BEATS - 1));
    end
  endgenerate

  assign pushWord = beatFire & (wordDone | sTlast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accData <= '0;
      accMask <= '0;
      lane    <= '0;
    end else if (ctl.clear) begin
      accData <= '0;
      accMask <= '0;
      lane    <= '0;
    end else if (beatFire) begin
      if (pushWord) begin
        accData <= '0;
        accMask <= '0;
        lane    <= '0;
      end else begin
        accData <= newData;
        accMask <= newMask;
        lane    <= lane + 1'b1;
      end
    end
  end

  // word FIFO
  fifoWord_t        mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic             doPop;

  assign doPop = ctl.pop & ~empty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushWord) begin
      mem[wrPtr] <= '{last: sTlast, mask: newMask, data: newData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushWord) wrPtr <= nextPtr(wrPtr);
      if (doPop)    rdPtr <= nextPtr(rdPtr);
      case ({pushWord, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head    = mem[rdPtr];
  assign empty   = (count == '0);
  assign full    = (count == LVL_W'(DEPTH));
  assign level   = count;
  assign sTready = ctl.acceptEn & ~full;
  assign mTvalid = ctl.dmaMode & ~empty;
endmodule

// File: rtl/strm_rx_control.sv
module strm_rx_control
  import strm_rx_pkg::*;
#(
  parameter int LVL_W      = 5,
  parameter int THRESH_RST = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cpuAddr,
  input  logic              cpuWrEn,
  input  logic [31:0]       cpuWrData,
  input  logic              cpuRdEn,
  input  fifoWord_t         head,
  input  logic              empty,
  input  logic              full,
  input  logic [LVL_W-1:0]  level,
  input  logic              mTready,
  output ctlStrobes_t       ctl,
  output logic [31:0]       cpuRdData,
  output logic              irq
);
  logic             enable, dmaMode, clrPulse;
  logic [31:0]      threshold;
  logic             lastFlag;
  logic [LANES-1:0] lastMask;
  logic             popReq;

  assign popReq = dmaMode ? mTready : (cpuRdEn && cpuAddr == REG_DATA);

  assign ctl.pop      = popReq & ~empty & ~clrPulse;
  assign ctl.clear    = clrPulse;
  assign ctl.acceptEn = enable & ~clrPulse;
  assign ctl.dmaMode  = dmaMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      dmaMode   <= 1'b0;
      clrPulse  <= 1'b0;
      threshold <= 32'(THRESH_RST);
    end else begin
      clrPulse <= 1'b0;
      if (cpuWrEn && cpuAddr == REG_CTRL) begin
        enable   <= cpuWrData[0];
        clrPulse <= cpuWrData[1];
        dmaMode  <= cpuWrData[2];
      end
      if (cpuWrEn && cpuAddr == REG_THRESH) begin
        threshold <= cpuWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastFlag <= 1'b0;
      lastMask <= '0;
    end else if (clrPulse) begin
      lastFlag <= 1'b0;
      lastMask <= '0;
    end else if (ctl.pop) begin
      lastFlag <= head.last;
      lastMask <= head.mask;
    end
  end

  always_comb begin
    case (cpuAddr)
      REG_DATA:   cpuRdData = empty ? 32'd0 : head.data;
      REG_STATUS: cpuRdData = {24'd0, lastMask, 1'b0, lastFlag, full, empty};
      REG_CTRL:   cpuRdData = {29'd0, dmaMode, 1'b0, enable};
      REG_THRESH: cpuRdData = threshold;
      REG_LEVEL:  cpuRdData = 32'(level);
      default:    cpuRdData = 32'd0;
    endcase
  end

  assign irq = (32'(level) >= threshold);
endmodule

// File: rtl/strm_rx_buffer.sv
module strm_rx_buffer
  import strm_rx_pkg::*;
#(
  parameter int TDATA_W    = 8,
  parameter int DEPTH      = 16,
  parameter int THRESH_RST = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TDATA_W-1:0] sTdata,
  input  logic               sTvalid,
  output logic               sTready,
  input  logic               sTlast,
  output logic [31:0]        mTdata,
  output logic [3:0]         mTkeep,
  output logic               mTlast,
  output logic               mTvalid,
  input  logic               mTready,
  input  logic [2:0]         cpuAddr,
  input  logic               cpuWrEn,
  input  logic [31:0]        cpuWrData,
  input  logic               cpuRdEn,
  output logic [31:0]        cpuRdData,
  output logic               irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  ctlStrobes_t      ctl;
  fifoWord_t        head;
  logic             empty, full;
  logic [LVL_W-1:0] level;

  strm_rx_datapath #(.TDATA_W(TDATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sTdata(sTdata), .sTvalid(sTvalid), .sTlast(sTlast), .sTready(sTready),
    .head(head), .empty(empty), .full(full), .level(level), .mTvalid(mTvalid)
  );

  strm_rx_control #(.LVL_W(LVL_W), .THRESH_RST(THRESH_RST)) i_ctl (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn),
    .head(head), .empty(empty), .full(full), .level(level), .mTready(mTready),
    .ctl(ctl), .cpuRdData(cpuRdData), .irq(irq)
  );

  assign mTdata = head.data;
  assign mTkeep = head.mask;
  assign mTlast = head.last;
endmodule

// File: rtl/strm_rx_checker.sv
module strm_rx_checker
  import strm_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             sTready,
  input logic             mTvalid,
  input ctlStrobes_t      ctl,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             empty
);
  a_r6_no_ready_when_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !sTready);

  a_r5_ready_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.acceptEn |-> !sTready);

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  a_r8_level_step: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clear |=> (level == $past(level)) || (level == $past(level) + LVL_W'(1))
                   || (level == $past(level) - LVL_W'(1)));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> empty);

  a_r10_no_dma_valid: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.dmaMode |-> !mTvalid);
endmodule

bind strm_rx_buffer strm_rx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rstN(rstN), .sTready(sTready), .mTvalid(mTvalid),
  .ctl(ctl), .level(level), .full(full), .empty(empty)
);

// File: tb/test_strm_rx_buffer.sv
`timescale 1ns/1ps
module test_strm_rx_buffer;
  localparam int TDATA_W = 8;
  localparam int DEPTH   = 16;
  localparam int BEATS   = 32 / TDATA_W;
  localparam int BYTES   = TDATA_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TDATA_W-1:0] sTdata = '0;
  logic sTvalid = 1'b0, sTlast = 1'b0, sTready;
  logic [31:0] mTdata;
  logic [3:0]  mTkeep;
  logic mTlast, mTvalid;
  logic mTready = 1'b0;
  logic [2:0]  cpuAddr = '0;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic irq;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  strm_rx_buffer #(.TDATA_W(TDATA_W), .DEPTH(DEPTH)) i_strm_rx_buffer (
    .clk(clk), .rstN(rstN),
    .sTdata(sTdata), .sTvalid(sTvalid), .sTready(sTready), .sTlast(sTlast),
    .mTdata(mTdata), .mTkeep(mTkeep), .mTlast(mTlast), .mTvalid(mTvalid), .mTready(mTready),
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn),
    .cpuRdData(cpuRdData), .irq(irq)
  );

  // bench model: {last, mask[3:0], data[31:0]}
  logic [36:0] expQ[$];
  logic [31:0] mAcc = '0;
  logic [3:0]  mMask = '0;
  int          mLane = 0;

  task automatic modelBeat(input logic [TDATA_W-1:0] d, input logic l);
    mAcc  = mAcc | (32'(d) << (mLane * TDATA_W));
    mMask = mMask | (4'((1 << BYTES) - 1) << (mLane * BYTES));
    if (mLane == BEATS - 1 || l) begin
      expQ.push_back({l, mMask, mAcc});
      mAcc = '0; mMask = '0; mLane = 0;
    end else begin
      mLane++;
    end
  endtask

  task automatic modelClear();
    expQ.delete();
    mAcc = '0; mMask = '0; mLane = 0;
  endtask

  task automatic checkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendBeat(input logic [TDATA_W-1:0] d, input logic l);
    @(negedge clk);
    sTdata = d; sTlast = l; sTvalid = 1'b1;
    #1;
    while (!sTready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 sTvalid = 1'b0; sTlast = 1'b0;
    modelBeat(d, l);
  endtask

  task automatic cpuWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(posedge clk);
    #1 cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRdEn = 1'b1;
    #1 d = cpuRdData;
    @(posedge clk);
    #1 cpuRdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a;
    #1 d = cpuRdData;
  endtask

  task automatic drainCheck(input string req);
    logic [31:0] d, st;
    logic [36:0] e;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      cpuRead(3'd0, d);
      checkEq(req, "data", d, e[31:0]);
      peek(3'd1, st);
      checkEq(req, "status last/mask", {27'd0, st[7:4], st[2]}, {27'd0, e[35:32], e[36]});
    end
    peek(3'd1, st);
    checkEq(req, "empty after drain", {31'd0, st[0]}, 32'd1);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    @(negedge clk); #1;
    checkEq("R5", "ready after reset", {31'd0, sTready}, 32'd0);
    checkEq("R9", "irq after reset", {31'd0, irq}, 32'd0);
    peek(3'd4, d); checkEq("R8", "level after reset", d, 32'd0);
    peek(3'd1, d); checkEq("R4", "status after reset", d, 32'h1);
    peek(3'd3, d); checkEq("R9", "threshold reset", d, 32'd1);
    cpuRead(3'd0, d); checkEq("R3", "empty read", d, 32'd0);
    peek(3'd4, d); checkEq("R3", "empty read no pop", d, 32'd0);

    // enable, full word
    cpuWrite(3'd2, 32'h1);
    sendBeat(8'h11, 1'b0); sendBeat(8'h22, 1'b0); sendBeat(8'h33, 1'b0); sendBeat(8'h44, 1'b0);
    peek(3'd4, d); checkEq("R8", "level one word", d, 32'd1);
    #1 checkEq("R9", "irq level>=1", {31'd0, irq}, 32'd1);
    peek(3'd0, d); checkEq("R1", "little-endian packing", d, 32'h44332211);
    drainCheck("R1");
    #1 checkEq("R9", "irq drop", {31'd0, irq}, 32'd0);

    // partial frames of 1, 2, 3 beats
    sendBeat(8'hA1, 1'b1);
    sendBeat(8'hB1, 1'b0); sendBeat(8'hB2, 1'b1);
    sendBeat(8'hC1, 1'b0); sendBeat(8'hC2, 1'b0); sendBeat(8'hC3, 1'b1);
    peek(3'd0, d); checkEq("R2", "one-beat flush zero fill", d, 32'h000000A1);
    drainCheck("R2");
    peek(3'd1, d); checkEq("R4", "last mask 3-beat", {24'd0, d[7:0]}, 32'h75);

    // disabled stream
    cpuWrite(3'd2, 32'h0);
    @(negedge clk); #1;
    checkEq("R5", "ready low when disabled", {31'd0, sTready}, 32'd0);
    sTvalid = 1'b1; sTdata = 8'h77; sTlast = 1'b1;
    repeat (3) @(posedge clk);
    #1 sTvalid = 1'b0; sTlast = 1'b0;
    peek(3'd4, d); checkEq("R5", "no accept while disabled", d, 32'd0);
    cpuWrite(3'd2, 32'h1);

    // fill to depth
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < BEATS; b++) sendBeat(8'(w * 16 + b), 1'b0);
    @(negedge clk); #1;
    checkEq("R6", "ready low when full", {31'd0, sTready}, 32'd0);
    peek(3'd4, d); checkEq("R8", "level at depth", d, 32'(DEPTH));
    peek(3'd1, d); checkEq("R4", "full flag", {31'd0, d[1]}, 32'd1);
    cpuWrite(3'd3, 32'(DEPTH));
    #1 checkEq("R9", "irq at level==threshold", {31'd0, irq}, 32'd1);
    cpuWrite(3'd3, 32'(DEPTH + 1));
    #1 checkEq("R9", "irq below threshold", {31'd0, irq}, 32'd0);
    @(negedge clk);
    sTvalid = 1'b1; sTdata = 8'h99; sTlast = 1'b1;
    repeat (3) @(posedge clk);
    #1 sTvalid = 1'b0; sTlast = 1'b0;
    peek(3'd4, d); checkEq("R6", "no accept when full", d, 32'(DEPTH));
    drainCheck("R6");
    cpuWrite(3'd3, 32'd1);

    // soft reset
    sendBeat(8'hE1, 1'b1);
    cpuRead(3'd0, d);
    void'(expQ.pop_front());
    sendBeat(8'hF1, 1'b0); sendBeat(8'hF2, 1'b0); sendBeat(8'hF3, 1'b0); sendBeat(8'hF4, 1'b0);
    sendBeat(8'hAA, 1'b0); sendBeat(8'hBB, 1'b0);
    cpuWrite(3'd2, 32'h3);
    @(posedge clk);
    modelClear();
    peek(3'd4, d); checkEq("R7", "level cleared", d, 32'd0);
    peek(3'd1, d); checkEq("R7", "status cleared", d, 32'h1);
    peek(3'd2, d); checkEq("R7", "ctrl keeps enable", d, 32'h1);
    sendBeat(8'h01, 1'b0); sendBeat(8'h02, 1'b0); sendBeat(8'h03, 1'b0); sendBeat(8'h04, 1'b0);
    peek(3'd0, d); checkEq("R7", "partial word dropped", d, 32'h04030201);
    drainCheck("R7");

    // DMA drain
    cpuWrite(3'd2, 32'h5);
    sendBeat(8'hAA, 1'b0); sendBeat(8'hBB, 1'b0); sendBeat(8'hCC, 1'b1);
    @(negedge clk); #1;
    checkEq("R10", "mTvalid", {31'd0, mTvalid}, 32'd1);
    checkEq("R10", "mTdata", mTdata, 32'h00CCBBAA);
    checkEq("R10", "mTkeep/mTlast", {27'd0, mTkeep, mTlast}, {27'd0, 4'h7, 1'b1});
    cpuRead(3'd0, d);
    peek(3'd4, d); checkEq("R10", "cpu read no pop in dma", d, 32'd1);
    @(negedge clk); mTready = 1'b1;
    @(posedge clk); #1 mTready = 1'b0;
    void'(expQ.pop_front());
    peek(3'd4, d); checkEq("R10", "dma pop", d, 32'd0);
    #1 checkEq("R10", "mTvalid empty", {31'd0, mTvalid}, 32'd0);
    peek(3'd1, d); checkEq("R4", "status after dma pop", {24'd0, d[7:0]}, 32'h75);
    cpuWrite(3'd2, 32'h1);
    sendBeat(8'h5A, 1'b1);
    @(negedge clk); #1;
    checkEq("R10", "mTvalid low when not dma", {31'd0, mTvalid}, 32'd0);
    drainCheck("R3");

    // random frames
    for (int f = 0; f < 30; f++) begin
      int len;
      len = 1 + int'($urandom % 9);
      for (int b = 0; b < len; b++) sendBeat(8'($urandom), (b == len - 1));
      drainCheck("R2");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule